// File: doc/BRIEF.md
# Three-Operand Integer Multiply-Divide Unit

This execution unit serves a 64-bit integer core. It runs signed and unsigned multiply, quotient and remainder operations in a 32-bit form and a 64-bit form. Each result goes straight to one destination register, so the unit keeps no separate high/low result pair. Divide-by-zero and signed overflow never trap. Each has a fixed result that is built into the datapath. The same twelve operations can arrive under two different opcode layouts. Each layout lives in its own major-opcode class, and a variant select picks which layout the core currently accepts.

The core presents the class select, the variant select, the 6-bit function field, the destination index and both operands together with a one-cycle `start`. Multiplies, special-case operations, illegal opcodes and writes to register zero finish in a single cycle. Ordinary quotient and remainder operations run a one-bit-per-cycle restoring divider, with 32 or 64 steps set by the operand width. Every accepted `start` produces exactly one `done` pulse. That pulse carries the result, a write-enable and an illegal flag.

Top module: `muldiv3`

## Requirements
- R1: After reset `busy`, `done`, `wrEn` and `illegal` are low and `result` is zero.
- R2: When `destIdx` is 0, a legal operation finishes one cycle after it is accepted. It raises `done` with `wrEn` low and `result` zero.
- R3: A 32-bit multiply, signed or unsigned, returns the low 32 bits of the product sign-extended from bit 31. Operand bits 63:32 have no effect.
- R4: A 64-bit multiply, signed or unsigned, returns the low 64 bits of the product.
- R5: A 32-bit quotient or remainder uses operand bits 31:0 only, read as signed or unsigned. The result is sign-extended from bit 31. A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R6: A 64-bit quotient or remainder returns the full 64-bit value, with the same rounding and sign rules as R5.
- R7: Any quotient or remainder whose divisor is zero at the operation's width returns 0 with `wrEn` high, one cycle after acceptance.
- R8: A signed quotient of the most negative value by -1 returns the dividend; for the 32-bit form this is bits 31:0 sign-extended. The matching signed remainder returns 0. Both finish one cycle after acceptance.
- R9: With `opClass`=0, the function codes are: 0x10 mul32, 0x11 mul64, 0x12 mul32u, 0x13 mul64u, 0x14 div32, 0x15 div64, 0x16 div32u, 0x17 div64u, 0x1c rem32, 0x1d rem64, 0x1e rem32u, 0x1f rem64u.
- R10: With `opClass`=1, the function codes are: 0x18 mul32, 0x19 mul32u, 0x1a div32, 0x1b div32u, 0x1c mul64, 0x1d mul64u, 0x1e div64, 0x1f div64u, 0x22 rem32, 0x23 rem32u, 0x26 rem64, 0x27 rem64u.
- R11: An opcode is illegal when `opClass` differs from `encSel`, or when its code is absent from the table of its class. An illegal opcode finishes one cycle after acceptance with `illegal` high, `wrEn` low and `result` zero.
- R12: Multiplies finish one cycle after acceptance. An iterating quotient or remainder finishes after 33 cycles (32-bit) or 65 cycles (64-bit), and `busy` is high in between. `done` is a one-cycle pulse, issued once per accepted start.
- R13: A `start` that arrives while `busy` is high is ignored. It produces no `done`, and it does not disturb the operation in flight, even when the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept the presented operation when not busy |
| opClass | input | 1 | Major-opcode class of the operation (0 or 1) |
| encSel | input | 1 | Opcode layout currently accepted (0 or 1) |
| funct | input | 6 | Function field |
| destIdx | input | 5 | Destination register index |
| opA | input | 64 | First operand (dividend / multiplicand) |
| opB | input | 64 | Second operand (divisor / multiplier) |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Value to write to the destination register |
| wrEn | output | 1 | Write the destination register with `result` |
| illegal | output | 1 | The accepted opcode was not legal |

## Verification
A shift register, partial remainder or step counter that goes wrong inside the divider stays hidden until its `done` pulse. It then shows either as a wrong `result` or as a `done` that comes earlier or later than the 33- or 65-cycle mark. Checking latency as well as value therefore catches counter faults that happen to leave the arithmetic right. A decode fault shows up one cycle after acceptance as a swapped operation, a missing `illegal`, or a write-enable that ignores register zero. Corrupted state held by the control shows as an extra or missing `done`, which throws the result queue out of step at once.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;
  localparam int XLEN  = 64;
  localparam int HALF  = XLEN / 2;
  localparam int CNT_W = $clog2(XLEN);
  localparam int IDX_W = 5;
  localparam int FN_W  = 6;

  typedef enum logic [1:0] {K_MUL, K_DIV, K_MOD} opKind_e;

  typedef struct packed {
    logic     legal;
    opKind_e  kind;
    logic     sgn;
    logic     wide;
  } decOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic step;
    logic takeFast;
    logic takeDiv;
  } ctlStrobe_t;

  function automatic logic [XLEN-1:0] sextHalf(input logic [HALF-1:0] v);
    return {{HALF{v[HALF-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] zextHalf(input logic [HALF-1:0] v);
    return {{HALF{1'b0}}, v};
  endfunction
endpackage

// File: rtl/muldiv_decode.sv
`timescale 1ns/1ps
module muldiv_decode
  import muldiv_pkg::*;
(
  input  logic            opClass,
  input  logic            encSel,
  input  logic [FN_W-1:0] funct,
  output decOp_t          dec
);
  decOp_t decA;
  decOp_t decB;
  localparam decOp_t NONE = '{legal: 1'b0, kind: K_MUL, sgn: 1'b0, wide: 1'b0};

  // layout 0: bit0 width, bit1 unsigned, bits 3:2 select the operation
  always_comb begin
    decA = NONE;
    if (funct[5:4] == 2'b01) begin
      decA.wide = funct[0];
      decA.sgn  = ~funct[1];
      unique case (funct[3:2])
        2'b00:   begin decA.kind = K_MUL; decA.legal = 1'b1; end
        2'b01:   begin decA.kind = K_DIV; decA.legal = 1'b1; end
        2'b11:   begin decA.kind = K_MOD; decA.legal = 1'b1; end
        default: decA.legal = 1'b0;
      endcase
    end
  end

  // layout 1: bit0 unsigned, bit2 width, group picked by bits 5:3 and bit1
  always_comb begin
    decB = NONE;
    decB.wide = funct[2];
    decB.sgn  = ~funct[0];
    if (funct[5:3] == 3'b011) begin
      decB.kind  = funct[1] ? K_DIV : K_MUL;
      decB.legal = 1'b1;
    end else if (funct[5:3] == 3'b100 && funct[1]) begin
      decB.kind  = K_MOD;
      decB.legal = 1'b1;
    end
  end

  always_comb begin
    if (opClass != encSel) dec = NONE;
    else if (opClass)      dec = decB;
    else                   dec = decA;
  end
endmodule

// File: rtl/muldiv_dpath.sv
`timescale 1ns/1ps
module muldiv_dpath
  import muldiv_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      stb,
  input  decOp_t          dec,
  input  logic            destZero,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            needIter,
  output logic [XLEN-1:0] result
);
  localparam logic [XLEN-1:0] MIN_W = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [HALF-1:0] MIN_H = {1'b1, {(HALF-1){1'b0}}};

  logic [XLEN-1:0] aExt, bExt, magA, magB, minVal, prod, mulRes, fastRes;
  logic            negA, negB, divZero, ovf;

  // operand preparation and one-cycle results
  always_comb begin
    if (dec.wide) begin
      aExt = opA;
      bExt = opB;
    end else if (dec.sgn) begin
      aExt = sextHalf(opA[HALF-1:0]);
      bExt = sextHalf(opB[HALF-1:0]);
    end else begin
      aExt = zextHalf(opA[HALF-1:0]);
      bExt = zextHalf(opB[HALF-1:0]);
    end
    negA    = dec.sgn & aExt[XLEN-1];
    negB    = dec.sgn & bExt[XLEN-1];
    magA    = negA ? (~aExt + 1'b1) : aExt;
    magB    = negB ? (~bExt + 1'b1) : bExt;
    minVal  = dec.wide ? MIN_W : sextHalf(MIN_H);
    divZero = (bExt == '0);
    ovf     = dec.sgn && (bExt == '1) && (aExt == minVal);
    prod    = opA * opB;
    mulRes  = dec.wide ? prod : sextHalf(prod[HALF-1:0]);

    if (!dec.legal || destZero)  fastRes = '0;
    else if (dec.kind == K_MUL)  fastRes = mulRes;
    else if (divZero)            fastRes = '0;
    else if (dec.kind == K_DIV)  fastRes = aExt;
    else                         fastRes = '0;

    needIter = dec.legal && !destZero && (dec.kind != K_MUL) && !divZero && !ovf;
  end

  // restoring divider state
  logic [XLEN-1:0] divisorR, dvdR, remR;
  logic            negQR, negRR, isDivR, wideR;
  logic [XLEN:0]   remSh;
  logic            ge;
  logic [XLEN-1:0] remNx, dvdNx, quoMag, quoS, remS, pick, finalRes;

  always_comb begin
    remSh  = {remR, dvdR[XLEN-1]};
    ge     = (remSh >= {1'b0, divisorR});
    remNx  = ge ? XLEN'(remSh - {1'b0, divisorR}) : remSh[XLEN-1:0];
    dvdNx  = {dvdR[XLEN-2:0], ge};
    quoMag = wideR ? dvdNx : zextHalf(dvdNx[HALF-1:0]);
    quoS   = negQR ? (~quoMag + 1'b1) : quoMag;
    remS   = negRR ? (~remNx + 1'b1) : remNx;
    pick   = isDivR ? quoS : remS;
    finalRes = wideR ? pick : sextHalf(pick[HALF-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisorR <= '0;
      dvdR     <= '0;
      remR     <= '0;
      negQR    <= 1'b0;
      negRR    <= 1'b0;
      isDivR   <= 1'b0;
      wideR    <= 1'b0;
    end else if (stb.capture) begin
      divisorR <= magB;
      dvdR     <= dec.wide ? magA : {magA[HALF-1:0], {HALF{1'b0}}};
      remR     <= '0;
      negQR    <= negA ^ negB;
      negRR    <= negA;
      isDivR   <= (dec.kind == K_DIV);
      wideR    <= dec.wide;
    end else if (stb.step) begin
      remR <= remNx;
      dvdR <= dvdNx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (stb.takeFast) result <= fastRes;
    else if (stb.takeDiv)  result <= finalRes;
  end
endmodule

// File: rtl/muldiv_ctrl.sv
`timescale 1ns/1ps
module muldiv_ctrl
  import muldiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       decLegal,
  input  logic       decWide,
  input  logic       destZero,
  input  logic       needIter,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       wrEn,
  output logic       illegal
);
  typedef enum logic {S_IDLE, S_DIV} state_e;
  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic              wideR;
  logic              accept, lastStep;

  always_comb begin
    accept       = start && (state == S_IDLE);
    lastStep     = (cnt == (wideR ? CNT_W'(XLEN-1) : CNT_W'(HALF-1)));
    stb.capture  = accept && needIter;
    stb.takeFast = accept && !needIter;
    stb.step     = (state == S_DIV);
    stb.takeDiv  = (state == S_DIV) && lastStep;
    busy         = (state == S_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      wideR   <= 1'b0;
      done    <= 1'b0;
      wrEn    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= stb.takeFast || stb.takeDiv;
      wrEn    <= stb.takeFast ? (decLegal && !destZero) : stb.takeDiv;
      illegal <= stb.takeFast && !decLegal;
      if (stb.capture) begin
        state <= S_DIV;
        cnt   <= '0;
        wideR <= decWide;
      end else if (stb.takeDiv) begin
        state <= S_IDLE;
      end else if (stb.step) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/muldiv3.sv
`timescale 1ns/1ps
module muldiv3
  import muldiv_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            opClass,
  input  logic            encSel,
  input  logic [FN_W-1:0] funct,
  input  logic [IDX_W-1:0] destIdx,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result,
  output logic            wrEn,
  output logic            illegal
);
  decOp_t     dec;
  ctlStrobe_t stb;
  logic       needIter, destZero;
  logic       decLegal, decIsMul, decWide;

  assign destZero = (destIdx == '0);
  assign decLegal = dec.legal;
  assign decIsMul = (dec.kind == K_MUL);
  assign decWide  = dec.wide;

  muldiv_decode u_dec (
    .opClass (opClass),
    .encSel  (encSel),
    .funct   (funct),
    .dec     (dec)
  );

  muldiv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .decLegal (decLegal),
    .decWide  (decWide),
    .destZero (destZero),
    .needIter (needIter),
    .stb      (stb),
    .busy     (busy),
    .done     (done),
    .wrEn     (wrEn),
    .illegal  (illegal)
  );

  muldiv_dpath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dec      (dec),
    .destZero (destZero),
    .opA      (opA),
    .opB      (opB),
    .needIter (needIter),
    .result   (result)
  );
endmodule

// File: rtl/muldiv3_chk.sv
`timescale 1ns/1ps
module muldiv3_chk
  import muldiv_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [IDX_W-1:0] destIdx,
  input logic [XLEN-1:0]  opB,
  input logic             busy,
  input logic             done,
  input logic [XLEN-1:0]  result,
  input logic             wrEn,
  input logic             illegal,
  input logic             decLegal,
  input logic             decIsMul,
  input logic             decWide
);
  logic [CNT_W:0] busyCnt;
  logic           zeroDiv;
  logic           taken;

  assign zeroDiv = decWide ? (opB == '0) : (opB[HALF-1:0] == '0);
  assign taken   = start && !busy;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  a_r12_busy_no_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  a_r12_mul_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (taken && decLegal && decIsMul) |=> (done && !busy));

  a_r12_div_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < (CNT_W+1)'(XLEN)));

  a_r11_illegal_no_write: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (done && !wrEn && result == '0));

  a_r7_zero_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (taken && decLegal && !decIsMul && zeroDiv && destIdx != '0)
      |=> (done && wrEn && result == '0));

  a_r2_zero_dest: assert property (@(posedge clk) disable iff (!rstN)
    (taken && destIdx == '0) |=> (done && !wrEn));

  a_r12_write_with_done: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> done);
endmodule

bind muldiv3 muldiv3_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .destIdx  (destIdx),
  .opB      (opB),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .wrEn     (wrEn),
  .illegal  (illegal),
  .decLegal (decLegal),
  .decIsMul (decIsMul),
  .decWide  (decWide)
);

// File: tb/muldiv3_bench.sv
`timescale 1ns/1ps
module muldiv3_bench;
  localparam int KMUL = 0, KDIV = 1, KMOD = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, opClass = 1'b0, encSel = 1'b0;
  logic [5:0]  funct = '0;
  logic [4:0]  destIdx = '0;
  logic [63:0] opA = '0, opB = '0;
  logic        busy, done, wrEn, illegal;
  logic [63:0] result;

  always #5 clk = ~clk;

  muldiv3 u_muldiv3 (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass), .encSel(encSel),
    .funct(funct), .destIdx(destIdx), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .result(result), .wrEn(wrEn), .illegal(illegal)
  );

  typedef struct {
    logic [63:0] res;
    logic        wr;
    logic        ill;
    longint      lat;
    longint      issued;
    string       tag;
  } exp_t;

  exp_t   sb[$];
  int     checks = 0, fails = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pop expected items as completions appear
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12 R13 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "result", result, e.res);
        chk(e.tag, "wrEn", {63'b0, wrEn}, {63'b0, e.wr});
        chk(e.tag, "illegal R11", {63'b0, illegal}, {63'b0, e.ill});
        chk(e.tag, "R12 latency", 64'(cyc - e.issued), 64'(e.lat));
      end
    end
  end

  function automatic logic [5:0] fcode(input bit varB, input int kind,
                                        input bit uns, input bit wide);
    if (!varB) begin
      case (kind)
        KMUL:    return 6'h10 | {4'b0, uns, wide};
        KDIV:    return 6'h14 | {4'b0, uns, wide};
        default: return 6'h1c | {4'b0, uns, wide};
      endcase
    end else begin
      case (kind)
        KMUL:    return 6'h18 | {3'b0, wide, 1'b0, uns};
        KDIV:    return 6'h1a | {3'b0, wide, 1'b0, uns};
        default: return 6'h22 | {3'b0, wide, 1'b0, uns};
      endcase
    end
  endfunction

  function automatic void model(input int kind, input bit uns, input bit wide,
                                input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] r, output bit fast);
    logic [63:0] p;
    logic signed [63:0] sa, sb2;
    logic signed [31:0] ha, hb;
    logic [31:0] ua, ub, t;
    fast = 1'b0;
    r = '0;
    if (kind == KMUL) begin
      p = a * b;
      r = wide ? p : {{32{p[31]}}, p[31:0]};
      fast = 1'b1;
    end else if (wide) begin
      sa = a; sb2 = b;
      if (b == 0) begin r = '0; fast = 1'b1; end
      else if (!uns && a == 64'h8000_0000_0000_0000 && b == '1) begin
        r = (kind == KDIV) ? a : 64'd0; fast = 1'b1;
      end else if (uns) r = (kind == KDIV) ? a / b : a % b;
      else              r = (kind == KDIV) ? sa / sb2 : sa % sb2;
    end else begin
      ua = a[31:0]; ub = b[31:0]; ha = ua; hb = ub;
      if (ub == 0) begin t = '0; fast = 1'b1; end
      else if (!uns && ua == 32'h8000_0000 && ub == '1) begin
        t = (kind == KDIV) ? ua : 32'd0; fast = 1'b1;
      end else if (uns) t = (kind == KDIV) ? ua / ub : ua % ub;
      else              t = (kind == KDIV) ? ha / hb : ha % hb;
      r = {{32{t[31]}}, t};
    end
  endfunction

  task automatic issueRaw(input bit cls, input bit sel, input logic [5:0] f,
                          input logic [4:0] rd, input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] res, input bit wr, input bit ill,
                          input longint lat, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    opClass = cls; encSel = sel; funct = f; destIdx = rd; opA = a; opB = b;
    start = 1'b1;
    e.res = res; e.wr = wr; e.ill = ill; e.lat = lat; e.issued = cyc; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic op(input bit varB, input int kind, input bit uns, input bit wide,
                    input logic [4:0] rd, input logic [63:0] a, input logic [63:0] b,
                    input string tag);
    logic [63:0] r;
    bit fast;
    longint lat;
    model(kind, uns, wide, a, b, r, fast);
    if (rd == 0) r = '0;
    lat = (fast || rd == 0) ? 1 : (wide ? 65 : 33);
    issueRaw(varB, varB, fcode(varB, kind, uns, wide), rd, a, b, r, rd != 0, 1'b0, lat, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", {63'b0, busy}, 64'd0);
    chk("R1", "done", {63'b0, done}, 64'd0);
    chk("R1", "wrEn", {63'b0, wrEn}, 64'd0);
    chk("R1", "illegal", {63'b0, illegal}, 64'd0);
    chk("R1", "result", result, 64'd0);

    // multiplies
    op(0, KMUL, 0, 0, 5'd3, 64'h0000_0000_7FFF_FFFF, 64'd2, "R3 R9 mul32");
    op(1, KMUL, 1, 0, 5'd4, 64'hABCD_0000_8000_0001, 64'h1234_0000_0000_0003, "R3 R10 mul32u");
    op(0, KMUL, 1, 0, 5'd4, 64'hFFFF_FFFF_0000_0010, 64'h0000_0001_0000_0010, "R3 R9 mul32u");
    op(0, KMUL, 0, 1, 5'd5, -64'sd3, 64'd5, "R4 R9 mul64");
    op(1, KMUL, 1, 1, 5'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0002, "R4 R10 mul64u");
    op(1, KMUL, 0, 1, 5'd6, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, "R4 R10 mul64");

    // 32-bit quotient / remainder
    op(0, KDIV, 0, 0, 5'd7, -64'sd7, 64'd2, "R5 R9 div32");
    op(1, KMOD, 0, 0, 5'd7, -64'sd7, 64'd2, "R5 R10 rem32");
    op(0, KDIV, 1, 0, 5'd8, 64'h0000_0000_FFFF_FFFF, 64'd1, "R5 R9 div32u");
    op(1, KMOD, 1, 0, 5'd8, 64'h5555_0000_FFFF_FFFF, 64'd10, "R5 R10 rem32u");
    op(1, KDIV, 0, 0, 5'd9, 64'd100, -64'sd7, "R5 R10 div32");
    op(0, KMOD, 0, 0, 5'd9, 64'd100, -64'sd7, "R5 R9 rem32");
    op(1, KDIV, 1, 0, 5'd9, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5 R10 div32u");

    // 64-bit quotient / remainder
    op(0, KDIV, 0, 1, 5'd10, -64'sd100, 64'd7, "R6 R9 div64");
    op(1, KDIV, 1, 1, 5'd10, 64'hFFFF_FFFF_FFFF_FFF0, 64'd3, "R6 R10 div64u");
    op(0, KMOD, 0, 1, 5'd11, -64'sd100, 64'd7, "R6 R9 rem64");
    op(1, KMOD, 1, 1, 5'd11, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0001_2345_6789, "R6 R10 rem64u");
    op(1, KMOD, 0, 1, 5'd12, 64'h7FFF_FFFF_FFFF_FFFF, -64'sd2, "R6 R10 rem64");

    // zero divisor
    op(0, KDIV, 0, 0, 5'd13, 64'd55, 64'hFFFF_FFFF_0000_0000, "R7 div32 by 0");
    op(1, KDIV, 0, 1, 5'd13, 64'd55, 64'd0, "R7 div64 by 0");
    op(0, KMOD, 1, 1, 5'd13, 64'd55, 64'd0, "R7 rem64u by 0");
    op(1, KMOD, 0, 0, 5'd13, 64'd55, 64'h1000_0000_0000_0000, "R7 rem32 by 0");

    // signed overflow
    op(0, KDIV, 0, 0, 5'd14, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R8 div32 ovf");
    op(1, KMOD, 0, 0, 5'd14, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 rem32 ovf");
    op(1, KDIV, 0, 1, 5'd14, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 div64 ovf");
    op(0, KMOD, 0, 1, 5'd14, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R8 rem64 ovf");

    // destination zero
    op(0, KDIV, 0, 1, 5'd0, 64'd99, 64'd4, "R2 div64 rd0");
    op(1, KMUL, 0, 0, 5'd0, 64'd99, 64'd4, "R2 mul32 rd0");

    // illegal opcodes
    issueRaw(0, 1, 6'h14, 5'd3, 64'd9, 64'd3, 64'd0, 1'b0, 1'b1, 1, "R11 class mismatch");
    issueRaw(1, 0, 6'h1a, 5'd3, 64'd9, 64'd3, 64'd0, 1'b0, 1'b1, 1, "R11 class mismatch B");
    issueRaw(1, 1, 6'h20, 5'd3, 64'd9, 64'd3, 64'd0, 1'b0, 1'b1, 1, "R11 unassigned B");
    issueRaw(0, 0, 6'h18, 5'd3, 64'd9, 64'd3, 64'd0, 1'b0, 1'b1, 1, "R11 unassigned A");

    // start while busy is ignored
    op(0, KDIV, 1, 1, 5'd15, 64'h0123_4567_89AB_CDEF, 64'd1000, "R13 R6 div64u in flight");
    chk("R13", "busy", {63'b0, busy}, 64'd1);
    opClass = 1'b0; encSel = 1'b0; funct = 6'h10; destIdx = 5'd2;
    opA = 64'd7; opB = 64'd9; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0; opA = '0; opB = '0;
    chk("R13", "busy after poke", {63'b0, busy}, 64'd1);

    op(1, KMUL, 0, 0, 5'd1, 64'd6, 64'd7, "R10 R12 mul after div");

    @(negedge clk);
    while (sb.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R12", "pending items", 64'(sb.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule